// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Sequencer

This block is the bus side of a simple processor-style bus master. It takes an atomic read-modify-write request and runs it on the external bus. The request carries a byte address, an argument word, a modify operation and a lock flag. The block runs one or two read cycles to fetch the 32-bit operand. It then applies the modify operation and runs the same number of write cycles to store the result. The old operand is returned on a response channel.

When the lock flag is set, an active-low lock output covers the whole sequence, so the external arbiter keeps the bus with this master from the first read to the last write. Any agent that needs atomicity sets the flag; the block does not know or care why the lock is needed.

Inside a locked sequence, address-hold and back-off are still obeyed, but a bus-hold request waits until the sequence ends. An unlocked sequence gives up the bus to a hold request between any two of its cycles. The request and response channels use valid/ready handshakes. A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is low while a transaction is running, while a hold request is pending, or while an earlier response has not yet been accepted. `rsp_valid` and `rsp_data` stay unchanged until `rsp_ready` is seen high.

Top module: `rmw_lock_seq`

## Requirements
- R1: `lock_n` goes low in the same clock as the first `ads_n` of a locked request, and stays high for the whole of a request whose `req_lock` is 0.
- R2: Once low, `lock_n` stays low through every cycle of the sequence, including aborted and restarted cycles. It returns high in the clock after `rdy_n` is sampled low in the final write cycle.
- R3: A request whose address bits [1:0] are zero runs one read and then one write, to word `addr>>2`. Otherwise it runs two reads and then two writes: the first to word `addr>>2`, the second to word `(addr>>2)+1`. The active-low `bus_be_n[b]` is low exactly when byte `4*word+b` lies in `addr..addr+3`. `bus_wr` is 0 for reads and 1 for writes.
- R4: The operand is the four bytes `addr..addr+3`, least significant byte first. `rsp_data` returns the old operand. The new operand written back depends on `req_op`: 0 writes `req_arg`, 1 writes old+1, 2 writes old+`req_arg`, 3 writes old OR `req_arg`, all modulo 2^32.
- R5: `hlda` never goes high while `lock_n` is low. A hold request that is pending when a locked sequence ends gets `hlda` in the clock after the next idle clock. While `hlda` is high, `addr_en` and `drv_en` are low. `hlda` falls in the clock after `hold` is sampled low.
- R6: During an unlocked sequence, a hold request sampled at the end of a non-final cycle raises `hlda` before the sequence finishes. The sequence resumes correctly after `hold` is released.
- R7: `boff_n` sampled low in a T1 or T2 clock aborts the cycle, even if `rdy_n` is low in that same clock. The aborted cycle has no effect. `addr_en` and `drv_en` stay low, and `lock_n` keeps its level, until `boff_n` is sampled high. The same cycle then restarts from T1.
- R8: While `ahold` is high, `addr_en` is low. The bus cycle in progress still completes normally.
- R9: Each bus cycle spends exactly one clock in T1 with `ads_n` low, followed by T2 clocks until `rdy_n` is sampled low.
- R10: `req_ready` is high only when the block is idle, `hold` is low and no response is pending. A pending response keeps `rsp_valid` and `rsp_data` stable until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted at this edge when high with `req_valid` |
| req_lock | input | 1 | Run the sequence under lock |
| req_op | input | 2 | Modify operation (0 swap, 1 increment, 2 add, 3 OR) |
| req_addr | input | AW | Byte address of the 32-bit operand |
| req_arg | input | DW | Argument for swap, add and OR |
| rsp_valid | output | 1 | Old operand available |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | DW | Old operand value |
| ads_n | output | 1 | Address strobe, low in T1 |
| bus_waddr | output | AW-2 | Word address of the current cycle |
| bus_be_n | output | DW/8 | Active-low byte enables |
| bus_wr | output | 1 | 1 for a write cycle |
| bus_dout | output | DW | Write data |
| bus_din | input | DW | Read data |
| rdy_n | input | 1 | Active-low cycle completion |
| addr_en | output | 1 | Drive enable for address and byte enables |
| drv_en | output | 1 | Drive enable for strobe, direction and data |
| lock_n | output | 1 | Active-low bus lock |
| hold | input | 1 | Bus-hold request |
| hlda | output | 1 | Bus-hold acknowledge |
| ahold | input | 1 | Address-hold request |
| boff_n | input | 1 | Active-low back-off |

## Verification
Two pairs of events can fall on the same clock edge. The first is back-off and ready. The bench raises `boff_n` low on exactly the edge where it returns `rdy_n` low, on a read and on a write inside locked and unlocked sequences. It then checks that the memory model and the returned operand show only the restarted cycle, and that the lock never lapsed. The second is a hold request against the end of a locked sequence. The bench raises `hold` right after acceptance and checks that `hlda` stays low until the final write completes, then rises one idle clock later. The same stimulus on an unlocked sequence must yield the bus between cycles.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_BOFF,
    ST_HOLD
  } bus_st_t;

  typedef enum logic [1:0] {
    OP_SWAP = 2'd0,
    OP_INC  = 2'd1,
    OP_ADD  = 2'd2,
    OP_OR   = 2'd3
  } mod_op_t;

endpackage

// File: rtl/rmw_lane_map.sv
module rmw_lane_map #(
  parameter  int BL = 4,
  localparam int OW = $clog2(BL)
) (
  input  logic [OW-1:0] off,
  input  logic          hi,
  output logic [BL-1:0] be_n
);

  // low half covers lanes off..BL-1, high half covers lanes 0..off-1
  for (genvar i = 0; i < BL; i++) begin : g_lane
    assign be_n[i] = hi ? (off <= OW'(i)) : (off > OW'(i));
  end

endmodule

// File: rtl/rmw_modify.sv
module rmw_modify
  import rmw_pkg::*;
#(
  parameter int DW = 32
) (
  input  mod_op_t       op,
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] arg,
  output logic [DW-1:0] new_val
);

  always_comb begin
    unique case (op)
      OP_SWAP: new_val = arg;
      OP_INC:  new_val = old_val + DW'(1);
      OP_ADD:  new_val = old_val + arg;
      OP_OR:   new_val = old_val | arg;
      default: new_val = arg;
    endcase
  end

endmodule

// File: rtl/rmw_lock_seq.sv
module rmw_lock_seq
  import rmw_pkg::*;
#(
  parameter  int AW  = 16,
  parameter  int DW  = 32,
  localparam int BL  = DW / 8,
  localparam int OW  = $clog2(BL),
  localparam int WAW = AW - OW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_lock,
  input  logic [1:0]     req_op,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_arg,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [DW-1:0]  rsp_data,
  output logic           ads_n,
  output logic [WAW-1:0] bus_waddr,
  output logic [BL-1:0]  bus_be_n,
  output logic           bus_wr,
  output logic [DW-1:0]  bus_dout,
  input  logic [DW-1:0]  bus_din,
  input  logic           rdy_n,
  output logic           addr_en,
  output logic           drv_en,
  output logic           lock_n,
  input  logic           hold,
  output logic           hlda,
  input  logic           ahold,
  input  logic           boff_n
);

  localparam int SHW = OW + 3;

  bus_st_t        st;
  logic [1:0]     cyc_idx;
  logic           busy;
  logic           cur_lock;
  mod_op_t        cur_op;
  logic [OW-1:0]  cur_off;
  logic [WAW-1:0] cur_wbase;
  logic [DW-1:0]  cur_arg;
  logic [DW-1:0]  rbuf [2];
  logic [2*DW-1:0] wwide;

  logic unal, half, is_wr, last_cyc, last_rd;
  logic in_bus, abort, cyc_done;
  logic [DW-1:0]   beat0, beat1, old_val, new_val;
  logic [2*DW-1:0] pair_sh, new_wide;
  logic [SHW-1:0]  sh_amt;

  // ---------------- sequence decode ----------------
  assign unal     = (cur_off != '0);
  assign half     = unal & cyc_idx[0];
  assign is_wr    = unal ? cyc_idx[1] : cyc_idx[0];
  assign last_cyc = unal ? (cyc_idx == 2'd3) : (cyc_idx == 2'd1);
  assign last_rd  = !is_wr && (unal ? cyc_idx[0] : 1'b1);

  assign in_bus   = (st == ST_T1) || (st == ST_T2);
  assign abort    = in_bus && !boff_n;                 // back-off beats ready
  assign cyc_done = (st == ST_T2) && boff_n && !rdy_n;

  // ---------------- operand assembly and modify ----------------
  assign beat0  = (cyc_done && !is_wr && !half) ? bus_din : rbuf[0];
  assign beat1  = (cyc_done && !is_wr &&  half) ? bus_din : rbuf[1];
  assign sh_amt = {cur_off, 3'b000};
  assign pair_sh = {beat1, beat0} >> sh_amt;
  assign old_val = pair_sh[DW-1:0];

  rmw_modify #(.DW(DW)) u_mod (
    .op      (cur_op),
    .old_val (old_val),
    .arg     (cur_arg),
    .new_val (new_val)
  );

  assign new_wide = {{DW{1'b0}}, new_val} << sh_amt;

  rmw_lane_map #(.BL(BL)) u_lanes (
    .off  (cur_off),
    .hi   (half),
    .be_n (bus_be_n)
  );

  // ---------------- outputs ----------------
  assign req_ready = (st == ST_IDLE) && !hold && !rsp_valid;
  assign ads_n     = (st != ST_T1);
  assign bus_wr    = is_wr;
  assign bus_waddr = cur_wbase + WAW'(half);
  assign bus_dout  = half ? wwide[2*DW-1:DW] : wwide[DW-1:0];
  assign drv_en    = (st != ST_BOFF) && (st != ST_HOLD);
  assign addr_en   = drv_en && !ahold;
  assign hlda      = (st == ST_HOLD);
  assign lock_n    = !(busy && cur_lock);

  // ---------------- sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cyc_idx   <= '0;
      busy      <= 1'b0;
      cur_lock  <= 1'b0;
      cur_op    <= OP_SWAP;
      cur_off   <= '0;
      cur_wbase <= '0;
      cur_arg   <= '0;
      wwide     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      for (int k = 0; k < 2; k++) rbuf[k] <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;

      if (cyc_done && !is_wr) begin
        for (int k = 0; k < 2; k++)
          if (half == k[0]) rbuf[k] <= bus_din;
      end
      if (cyc_done && last_rd) begin
        rsp_data <= old_val;
        wwide    <= new_wide;
      end

      unique case (st)
        ST_IDLE: begin
          if (hold) begin
            st <= ST_HOLD;
          end else if (req_valid && !rsp_valid) begin
            cur_lock  <= req_lock;
            cur_op    <= mod_op_t'(req_op);
            cur_off   <= req_addr[OW-1:0];
            cur_wbase <= req_addr[AW-1:OW];
            cur_arg   <= req_arg;
            cyc_idx   <= '0;
            busy      <= 1'b1;
            st        <= ST_T1;
          end
        end
        ST_T1: st <= abort ? ST_BOFF : ST_T2;
        ST_T2: begin
          if (abort) begin
            st <= ST_BOFF;
          end else if (cyc_done) begin
            if (last_cyc) begin
              st        <= ST_IDLE;
              busy      <= 1'b0;
              rsp_valid <= 1'b1;
            end else begin
              cyc_idx <= cyc_idx + 2'd1;
              st      <= (hold && !cur_lock) ? ST_HOLD : ST_T1;
            end
          end
        end
        ST_BOFF: if (boff_n) st <= ST_T1;
        ST_HOLD: if (!hold) st <= busy ? ST_T1 : ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  a_r1_lock_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> !ads_n);

  a_r2_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_n && !(cyc_done && last_cyc)) |=> !lock_n);

  a_r5_no_hlda_under_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_n |-> !hlda);

  a_r5_hold_floats: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!addr_en && !drv_en));

  a_r7_boff_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (st == ST_BOFF && !drv_en && !addr_en && $stable(lock_n)));

  a_r7_restart_t1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BOFF && boff_n) |=> !ads_n);

  a_r8_ahold_floats_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ahold |-> !addr_en);

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |=> ads_n);

  a_r10_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

endmodule

// File: tb/tb_rmw_lock_seq.sv
module tb_rmw_lock_seq;

  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_lock = 1'b0, rsp_ready = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_arg = '0, bus_din = '0;
  logic rdy_n = 1'b1, hold = 1'b0, ahold = 1'b0, boff_n = 1'b1;
  logic req_ready, rsp_valid, ads_n, bus_wr, addr_en, drv_en, lock_n, hlda;
  logic [DW-1:0] rsp_data, bus_dout;
  logic [AW-3:0] bus_waddr;
  logic [3:0] bus_be_n;

  rmw_lock_seq #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lock(req_lock), .req_op(req_op), .req_addr(req_addr), .req_arg(req_arg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ads_n(ads_n), .bus_waddr(bus_waddr), .bus_be_n(bus_be_n), .bus_wr(bus_wr),
    .bus_dout(bus_dout), .bus_din(bus_din), .rdy_n(rdy_n), .addr_en(addr_en),
    .drv_en(drv_en), .lock_n(lock_n), .hold(hold), .hlda(hlda), .ahold(ahold),
    .boff_n(boff_n)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_chk = 0, n_fail = 0, n_clk = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    n_clk++;
    if (n_clk > 150000) begin
      chk(1'b0, "watchdog", 64'(n_clk), 64'd150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- memory and bus responder ----------------
  logic [7:0] mem [0:63];
  int  waits = 0, cnt = 0, ncyc = 0, t_base = 0, t_n = 1;
  int  boff_cyc = -1, boff_left = 0;
  bit  in_cyc = 0, t_active = 0, t_lock = 0, boff_done = 0, lock_broke = 0;
  logic [AW-1:0] t_addr = '0;
  logic [13:0] lat_w;
  logic [3:0]  lat_be;
  logic        lat_wr;
  logic [31:0] lat_dat;

  function automatic logic [31:0] rd_word(input int w);
    return {mem[4*w+3], mem[4*w+2], mem[4*w+1], mem[4*w]};
  endfunction

  function automatic logic [31:0] rd_oper(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  function automatic logic [31:0] model_mod(input int op, input logic [31:0] o,
                                            input logic [31:0] g);
    case (op)
      0: return g;
      1: return o + 32'd1;
      2: return o + g;
      default: return o | g;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (boff_n == 1'b0 && t_active)
        chk(!drv_en && !addr_en && (lock_n == !t_lock), "R7 float during back-off",
            {61'd0, drv_en, addr_en, lock_n}, {61'd0, 2'b00, !t_lock});
      // outcome of the previous rising edge
      if (in_cyc && boff_n == 1'b0) begin
        in_cyc = 0;
      end else if (in_cyc && rdy_n == 1'b0) begin
        if (lat_wr)
          for (int b = 0; b < 4; b++)
            if (!lat_be[b]) mem[4*lat_w[3:0]+b] = lat_dat[8*b +: 8];
        in_cyc = 0;
        ncyc++;
        if (ncyc - t_base == 2 * t_n) begin
          t_active = 0;
          chk(lock_n == 1'b1, "R2 lock released after final write", 64'(lock_n), 64'd1);
          chk(!lock_broke, "R2 lock held through sequence", 64'(lock_broke), 64'd0);
        end
      end
      if (t_active && t_lock && lock_n) lock_broke = 1;
      // next drives
      rdy_n = 1'b1;
      if (boff_left > 0) begin boff_n = 1'b0; boff_left--; end
      else boff_n = 1'b1;
      if (!ads_n && drv_en) begin
        int ci, hf, w;
        logic [3:0] ebe;
        ci = ncyc - t_base;
        if (ci == 0) begin t_active = 1; lock_broke = 0; end
        hf = ci % t_n;
        w  = int'(t_addr >> 2) + hf;
        for (int b = 0; b < 4; b++)
          ebe[b] = !((4*w + b) >= int'(t_addr) && (4*w + b) < int'(t_addr) + 4);
        chk(lock_n == !t_lock, "R1 lock level at strobe", 64'(lock_n), 64'(!t_lock));
        chk(bus_waddr == 14'(w), "R3 word address", 64'(bus_waddr), 64'(w));
        chk(bus_be_n == ebe, "R3 byte enables", 64'(bus_be_n), 64'(ebe));
        chk(bus_wr == (ci >= t_n), "R3 direction", 64'(bus_wr), 64'(ci >= t_n));
        in_cyc = 1; cnt = waits;
        lat_w = bus_waddr; lat_be = bus_be_n; lat_wr = bus_wr; lat_dat = bus_dout;
      end else if (in_cyc) begin
        chk(ads_n, "R9 strobe only in T1", 64'(ads_n), 64'd1);
        if (cnt == 0) begin
          rdy_n   = 1'b0;
          bus_din = rd_word(int'(lat_w[3:0]));
          if (ncyc == boff_cyc && !boff_done) begin
            boff_n = 1'b0; boff_left = 2; boff_done = 1;
          end
        end else cnt--;
      end
    end
  end

  // ---------------- transaction driver ----------------
  task automatic do_txn(input logic [AW-1:0] a, input int op, input logic [31:0] arg,
                        input bit lk, input bit hmode, input bit amode);
    logic [31:0] old_v, new_v;
    old_v = rd_oper(int'(a));
    new_v = model_mod(op, old_v, arg);
    t_addr = a; t_lock = lk; t_n = (a[1:0] != 2'b00) ? 2 : 1; t_base = ncyc;
    req_addr = a; req_op = 2'(op); req_arg = arg; req_lock = lk; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10 not ready while busy", 64'(req_ready), 64'd0);
    if (amode) begin
      ahold = 1'b1;
      for (int i = 0; i < 3; i++) begin
        #1 chk(!addr_en, "R8 address floated under ahold", 64'(addr_en), 64'd0);
        @(negedge clk);
      end
      ahold = 1'b0;
    end
    if (hmode) begin
      hold = 1'b1;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (hlda || rsp_valid) break;
      end
      if (lk) begin
        chk(rsp_valid && !hlda, "R5 hold refused while locked", 64'(hlda), 64'd0);
        @(negedge clk);
        chk(hlda, "R5 hold granted after idle clock", 64'(hlda), 64'd1);
      end else begin
        chk(hlda && !rsp_valid, "R6 hold granted mid unlocked sequence",
            {62'd0, hlda, rsp_valid}, 64'b10);
      end
      chk(!addr_en && !drv_en, "R5 outputs floated under hlda",
          {62'd0, addr_en, drv_en}, 64'd0);
      hold = 1'b0;
      @(negedge clk);
      chk(!hlda, "R5 hlda released", 64'(hlda), 64'd0);
    end
    for (int i = 0; i < 300; i++) begin
      if (rsp_valid) break;
      @(negedge clk);
    end
    chk(rsp_valid, "R10 response arrives", 64'(rsp_valid), 64'd1);
    chk(rsp_data == old_v, "R4 old operand returned", 64'(rsp_data), 64'(old_v));
    chk(!req_ready, "R10 not ready with response pending", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk(rsp_valid && rsp_data == old_v, "R10 response held", 64'(rsp_data), 64'(old_v));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid, "R10 response consumed", 64'(rsp_valid), 64'd0);
    chk(rd_oper(int'(a)) == new_v, "R4 modified operand stored",
        64'(rd_oper(int'(a))), 64'(new_v));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 5);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ads_n && lock_n && !hlda && req_ready && !rsp_valid, "reset state",
        {59'd0, ads_n, lock_n, hlda, req_ready, rsp_valid}, 64'b11010);

    // sweep: lock x offset x op x wait states
    for (int lk = 0; lk < 2; lk++)
      for (int off = 0; off < 4; off++)
        for (int op = 0; op < 4; op++)
          for (int w = 0; w < 3; w++) begin
            int base;
            base  = (lk * 48 + off * 12 + op * 3 + w) % 14;
            waits = w;
            do_txn(AW'(base * 4 + off), op, 32'h1357_9BDF ^ 32'(base * 32'h0101_0101),
                   lk[0], 1'b0, 1'b0);
          end

    // back-off coinciding with ready: second read, first write, first read
    waits = 1;
    boff_cyc = ncyc + 1; boff_done = 0;
    do_txn(16'd9, 2, 32'h0000_00F1, 1'b1, 1'b0, 1'b0);     // R7 locked, read half
    boff_cyc = ncyc + 2; boff_done = 0;
    do_txn(16'd22, 0, 32'hCAFE_F00D, 1'b1, 1'b0, 1'b0);    // R7 locked, write
    boff_cyc = ncyc; boff_done = 0;
    do_txn(16'd40, 1, 32'd0, 1'b0, 1'b0, 1'b0);            // R7 unlocked, aligned
    boff_cyc = -1;

    // hold against locked and unlocked sequences
    waits = 2;
    do_txn(16'd13, 3, 32'h8000_0001, 1'b1, 1'b1, 1'b0);    // R5
    do_txn(16'd30, 2, 32'h0000_0100, 1'b0, 1'b1, 1'b0);    // R6
    do_txn(16'd4,  1, 32'd0,          1'b1, 1'b1, 1'b0);   // R5 aligned

    // address hold during a live cycle
    waits = 3;
    do_txn(16'd17, 0, 32'h0BAD_BEEF, 1'b1, 1'b0, 1'b1);    // R8

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule